// File: doc/BRIEF.md
# Paired Lookup-Table Logic Cell with Shared Flip-Flop

The cell holds two programmable 3-input lookup tables, called even and odd, and one sequential element that both tables share. Each table returns one bit of its own 8-bit truth table. For every table input, a 2-bit select picks the input's own pin, the flip-flop output, or a constant low. The sequential element has two modes. In bypass, the cell result is the even table output, with no register in the path. In D flip-flop mode, the even table supplies D and the odd table supplies the gate G. The flip-flop takes a new value only on a clock event while G is high. A clock event is either every system clock edge, or a rising transition on the even table's IN2 pin. An output enable gates the result onto `cell_out`.

A single controller holds the global enable, and it has two states. CELL_IDLE is the state after reset. In CELL_IDLE the configuration registers take writes, the flip-flop is held at 0 and `cell_out` is low. CELL_RUN is the active state, and in it the configuration is frozen. Transition START (CELL_IDLE to CELL_RUN) happens when address 5 is written with bit 0 set. Transition STOP (CELL_RUN to CELL_IDLE) happens when address 5 is written with bit 0 clear.

Setting table 0x55, routing the flip-flop output to IN0 and holding G high makes the cell toggle its output on every clock event, so it divides by two. A second cell whose IN2 is driven by the first cell's output divides the original signal by four.

Top module: `lut_pair_cell`

## Requirements
- R1: Each table output is bit {IN2,IN1,IN0} of its 8-bit truth table, with IN0 as the least significant index bit. In bypass mode (control bit 3 = 0), `cell_out` follows the even table output in the same cycle.
- R2: A truth table of 0xFF gives a constant 1 for every input pattern.
- R3: Input k of a table uses select bits [2k+1:2k] of that table's select register. The codes are: 00 = tie low, 01 = the table's own pin k, 10 = the flip-flop output, 11 = tie low.
- R4: In D flip-flop mode (control bit 3 = 1), the even table output is D and the odd table output is G. The flip-flop loads D on a clock event only when G = 1. While G = 0, Q holds its value.
- R5: Control bit 4 selects the clock event. With bit 4 = 0, every system clock edge is a clock event. With bit 4 = 1, a clock event is an edge at which `pin_even[2]` is 1 after being 0 in the previous cycle. A loaded value appears on `cell_out` in the cycle after the clock event.
- R6: With the flip-flop output selected on even IN0, even table 0x55 and G held at 1, Q toggles on every clock event, so the cell divides the event rate by two.
- R7: If a table's enable is 0 (control bit 0 for even, bit 1 for odd), that table's output is forced to 0. If the output enable (control bit 2) is 0, `cell_out` is 0. In CELL_IDLE, `cell_out` is 0 and Q is cleared, so after START, Q begins at 0.
- R8: While in CELL_RUN, writes to addresses 0 to 4 are ignored. Address 5 can be written in either state.
- R9: When a second cell's `pin_even[2]` is driven by a first cell that divides by two, and both cells are set up as dividers in IN2 clock mode, the second cell's output runs at one quarter of the first cell's IN2 rate.
- R10: After reset, all configuration registers are 0, the controller is in CELL_IDLE, Q is 0 and `cell_out` is 0.
- R11: The register map is as follows. Address 0 holds the even truth table and address 1 the odd truth table. Address 2 holds the even selects and address 3 the odd selects, each in bits [5:0]. Address 4 is the control register (bits 4:0 as above). Address 5 holds the global enable in bit 0. In bypass mode, Q is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pin_even | input | 3 | Pins for even table inputs IN0..IN2; bit 2 is also the IN2 clock source |
| pin_odd | input | 3 | Pins for odd table inputs IN0..IN2 |
| cell_out | output | 1 | Gated cell result |

## Verification
There are three kinds of result, and each falls due at a fixed cycle:
- **Bypass:** a result is due in the same cycle as the pin change that causes it, since no register lies in the path.
- **Flip-flop:** a value loaded by a clock event shows on `cell_out` exactly one cycle after that event. A write to address 5 takes effect on the edge that ends the write cycle, so the first clock event can occur on the following edge.
- **Chained cell:** the second cell sees the first cell's output as its IN2. Its load therefore happens one cycle after the first cell's output changes.

The driver keeps its own model of Q and of the previous IN2 level. Before each edge it pushes the value it expects for the current cycle. The monitor compares at the falling edge of that same cycle, so every check lands on the cycle in which the result is due.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int CFG_ADDR_W = 3;
    localparam int CFG_DATA_W = 8;
    localparam int LUT_N_IN   = 3;
    localparam int LUT_LEN    = 1 << LUT_N_IN;
    localparam int SEL_W      = 2 * LUT_N_IN;
    localparam int N_LUTS     = 2;

    localparam int ADDR_TT_EVEN  = 0;
    localparam int ADDR_TT_ODD   = 1;
    localparam int ADDR_SEL_EVEN = 2;
    localparam int ADDR_SEL_ODD  = 3;
    localparam int ADDR_CTRL     = 4;
    localparam int ADDR_GLOBAL   = 5;

    typedef enum logic [1:0] {
        SRC_TIE0 = 2'b00,
        SRC_PIN  = 2'b01,
        SRC_FB   = 2'b10,
        SRC_RSVD = 2'b11
    } src_sel_e;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_RUN  = 1'b1
    } cell_state_e;

    typedef struct packed {
        logic [LUT_LEN-1:0] tt_even;
        logic [LUT_LEN-1:0] tt_odd;
        logic [SEL_W-1:0]   sel_even;
        logic [SEL_W-1:0]   sel_odd;
        logic               clk_in2;
        logic               dff_mode;
        logic               out_en;
        logic               en_odd;
        logic               en_even;
    } cell_cfg_t;

endpackage

// File: rtl/lpc_cfg_regs.sv
module lpc_cfg_regs
    import lpc_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int DATA_W = CFG_DATA_W
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cell_cfg_t         cfg,
    output logic              run
);

    cell_state_e state_q;
    cell_state_e state_d;
    logic        glob_wr;
    logic        cfg_wr_ok;

    assign glob_wr = we && (addr == ADDR_W'(ADDR_GLOBAL));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions START and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: if (glob_wr && wdata[0])  state_d = CELL_RUN;
            CELL_RUN:  if (glob_wr && !wdata[0]) state_d = CELL_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        run       = 1'b0;
        cfg_wr_ok = 1'b0;
        unique case (state_q)
            CELL_IDLE: cfg_wr_ok = we;
            CELL_RUN:  run       = 1'b1;
        endcase
    end

    // configuration storage, writable only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr_ok) begin
            case (addr)
                ADDR_W'(ADDR_TT_EVEN):  cfg.tt_even  <= wdata[LUT_LEN-1:0];
                ADDR_W'(ADDR_TT_ODD):   cfg.tt_odd   <= wdata[LUT_LEN-1:0];
                ADDR_W'(ADDR_SEL_EVEN): cfg.sel_even <= wdata[SEL_W-1:0];
                ADDR_W'(ADDR_SEL_ODD):  cfg.sel_odd  <= wdata[SEL_W-1:0];
                ADDR_W'(ADDR_CTRL): begin
                    cfg.en_even  <= wdata[0];
                    cfg.en_odd   <= wdata[1];
                    cfg.out_en   <= wdata[2];
                    cfg.dff_mode <= wdata[3];
                    cfg.clk_in2  <= wdata[4];
                end
                default: ;
            endcase
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && we && !glob_wr) |=> $stable(cfg)); // R8

    AST_RUN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && glob_wr && wdata[0]) |=> run); // R11

endmodule

// File: rtl/lpc_lut3.sv
module lpc_lut3
    import lpc_pkg::*;
#(
    parameter  int N_IN   = LUT_N_IN,
    localparam int TT_LEN = 1 << N_IN
)
(
    input  logic [TT_LEN-1:0] table_i,
    input  logic [2*N_IN-1:0] sel_i,
    input  logic [N_IN-1:0]   pin_i,
    input  logic              fb_i,
    input  logic              en_i,
    output logic              y_o
);

    logic [N_IN-1:0] idx;

    for (genvar k = 0; k < N_IN; k++) begin : g_in
        src_sel_e src;
        logic     bit_v;
        assign src = src_sel_e'(sel_i[2*k +: 2]);
        always_comb begin
            unique case (src)
                SRC_TIE0: bit_v = 1'b0;
                SRC_PIN:  bit_v = pin_i[k];
                SRC_FB:   bit_v = fb_i;
                SRC_RSVD: bit_v = 1'b0;
            endcase
        end
        assign idx[k] = bit_v;
    end

    assign y_o = en_i & table_i[idx];

endmodule

// File: rtl/lpc_seq.sv
module lpc_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dff_mode,
    input  logic clk_in2,
    input  logic in2_pin,
    input  logic d,
    input  logic g,
    output logic q
);

    logic in2_prev;
    logic evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in2_prev <= 1'b0;
        end else begin
            in2_prev <= in2_pin;
        end
    end

    assign evt = clk_in2 ? (in2_pin & ~in2_prev) : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!run || !dff_mode) begin
            q <= 1'b0;
        end else if (evt && g) begin
            q <= d;
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q == 1'b0)); // R7

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dff_mode && !g) |=> $stable(q)); // R4

    AST_SYSCLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dff_mode && !clk_in2 && g) |=> (q == $past(d))); // R5

    AST_IN2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dff_mode && clk_in2 && !in2_pin) |=> $stable(q)); // R5

endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell
    import lpc_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int DATA_W = CFG_DATA_W,
    parameter int N_IN   = LUT_N_IN
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   pin_even,
    input  logic [N_IN-1:0]   pin_odd,
    output logic              cell_out
);

    localparam int TT_LEN = 1 << N_IN;

    cell_cfg_t         cfg;
    logic              run;
    logic              q;
    logic [N_LUTS-1:0] lut_y;

    logic [TT_LEN-1:0] tt_arr  [N_LUTS];
    logic [2*N_IN-1:0] sel_arr [N_LUTS];
    logic [N_IN-1:0]   pin_arr [N_LUTS];
    logic              en_arr  [N_LUTS];

    assign tt_arr[0]  = cfg.tt_even;
    assign tt_arr[1]  = cfg.tt_odd;
    assign sel_arr[0] = cfg.sel_even;
    assign sel_arr[1] = cfg.sel_odd;
    assign pin_arr[0] = pin_even;
    assign pin_arr[1] = pin_odd;
    assign en_arr[0]  = cfg.en_even;
    assign en_arr[1]  = cfg.en_odd;

    lpc_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .run   (run)
    );

    for (genvar i = 0; i < N_LUTS; i++) begin : g_lut
        lpc_lut3 #(
            .N_IN (N_IN)
        ) u_lut (
            .table_i (tt_arr[i]),
            .sel_i   (sel_arr[i]),
            .pin_i   (pin_arr[i]),
            .fb_i    (q),
            .en_i    (en_arr[i]),
            .y_o     (lut_y[i])
        );
    end

    lpc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .dff_mode (cfg.dff_mode),
        .clk_in2  (cfg.clk_in2),
        .in2_pin  (pin_even[N_IN-1]),
        .d        (lut_y[0]),
        .g        (lut_y[1]),
        .q        (q)
    );

    always_comb begin
        cell_out = run && cfg.out_en && (cfg.dff_mode ? q : lut_y[0]);
    end

    AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cell_out); // R7

endmodule

// File: tb/lut_pair_cell_tb.sv
module lut_pair_cell_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       a_we,    b_we;
    logic [2:0] a_addr,  b_addr;
    logic [7:0] a_wdata, b_wdata;
    logic [2:0] a_pe,    a_po, b_po;
    logic [2:0] b_pe;
    logic       a_out,   b_out;

    assign b_pe = {a_out, 2'b00};

    lut_pair_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(a_we), .cfg_addr(a_addr),
        .cfg_wdata(a_wdata), .pin_even(a_pe), .pin_odd(a_po), .cell_out(a_out)
    );

    lut_pair_cell u_chain (
        .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_addr(b_addr),
        .cfg_wdata(b_wdata), .pin_even(b_pe), .pin_odd(b_po), .cell_out(b_out)
    );

    typedef struct {
        int    due;
        int    which;
        logic  exp;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares due items at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            logic act;
            it  = sb_q.pop_front();
            act = (it.which == 0) ? a_out : b_out;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual=%b expected=%b cycle=%0d", it.tag, act, it.exp, cyc);
            end
        end
    end

    task automatic expect_out(int which, logic exp, string tag);
        exp_item_t it;
        it.due = cyc; it.which = which; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_a(logic [2:0] addr, logic [7:0] data);
        a_we = 1'b1; a_addr = addr; a_wdata = data;
        tick();
        a_we = 1'b0;
    endtask

    task automatic wr_b(logic [2:0] addr, logic [7:0] data);
        b_we = 1'b1; b_addr = addr; b_wdata = data;
        tick();
        b_we = 1'b0;
    endtask

    task automatic wr_both(logic [2:0] addr, logic [7:0] da, logic [7:0] db);
        a_we = 1'b1; a_addr = addr; a_wdata = da;
        b_we = 1'b1; b_addr = addr; b_wdata = db;
        tick();
        a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] tt;
        logic qa, qb, pa, pra, prb, eb;

        rst_n = 1'b0;
        a_we = 0; a_addr = 0; a_wdata = 0; a_pe = 0; a_po = 0;
        b_we = 0; b_addr = 0; b_wdata = 0; b_po = 0;
        tick(); tick();
        expect_out(0, 1'b0, "R10 reset out");
        expect_out(1, 1'b0, "R10 reset chain out");
        tick();
        rst_n = 1'b1;
        tick();
        expect_out(0, 1'b0, "R10 after reset");
        tick();

        // R1: bypass lookup over all input patterns
        tt = 8'hB2;
        wr_a(3'd2, 8'h15);
        wr_a(3'd0, tt);
        wr_a(3'd4, 8'h05);
        wr_a(3'd5, 8'h01);
        for (int i = 0; i < 8; i++) begin
            a_pe = 3'(i);
            expect_out(0, tt[i], "R1 lookup");
            tick();
        end

        // R3: IN0 pin, IN1 tie-low (00), IN2 reserved (11)
        wr_a(3'd5, 8'h00);
        wr_a(3'd2, 8'h31);
        wr_a(3'd5, 8'h01);
        a_pe = 3'b111; expect_out(0, tt[1], "R3 tie low 111"); tick();
        a_pe = 3'b011; expect_out(0, tt[1], "R3 tie low 011"); tick();
        a_pe = 3'b110; expect_out(0, tt[0], "R3 tie low 110"); tick();

        // R2: constant one
        wr_a(3'd5, 8'h00);
        wr_a(3'd2, 8'h15);
        wr_a(3'd0, 8'hFF);
        wr_a(3'd5, 8'h01);
        for (int i = 0; i < 8; i++) begin
            a_pe = 3'(i);
            expect_out(0, 1'b1, "R2 all ones");
            tick();
        end

        // R8: writes while running are ignored
        wr_a(3'd0, 8'h00);
        wr_a(3'd4, 8'h00);
        for (int i = 0; i < 4; i++) begin
            a_pe = 3'(i);
            expect_out(0, 1'b1, "R8 locked config");
            tick();
        end

        // R7: enables
        wr_a(3'd5, 8'h00);
        expect_out(0, 1'b0, "R7 global off");
        wr_a(3'd4, 8'h04);
        wr_a(3'd5, 8'h01);
        expect_out(0, 1'b0, "R7 lut disabled");
        wr_a(3'd5, 8'h00);
        wr_a(3'd4, 8'h01);
        wr_a(3'd5, 8'h01);
        expect_out(0, 1'b0, "R7 output enable low");
        wr_a(3'd5, 8'h00);

        // R5/R6: flip-flop on system clock, feedback inverter
        a_pe = 3'b000;
        a_po = 3'b001;
        wr_a(3'd2, 8'h02);
        wr_a(3'd0, 8'h55);
        wr_a(3'd1, 8'hAA);
        wr_a(3'd3, 8'h01);
        wr_a(3'd4, 8'h0F);
        wr_a(3'd5, 8'h01);
        qa = 1'b0;
        for (int i = 0; i < 6; i++) begin
            expect_out(0, qa, "R5 R6 sysclk toggle");
            tick();
            qa = ~qa;
        end
        // R4: gate low freezes Q
        a_po = 3'b000;
        for (int i = 0; i < 4; i++) begin
            expect_out(0, qa, "R4 gate low hold");
            tick();
        end
        a_po = 3'b001;
        for (int i = 0; i < 3; i++) begin
            expect_out(0, qa, "R4 gate high resume");
            tick();
            qa = ~qa;
        end

        // R5/R6: clock from IN2 rising transitions
        wr_a(3'd5, 8'h00);
        wr_a(3'd4, 8'h1F);
        wr_a(3'd5, 8'h01);
        qa = 1'b0; pra = 1'b0;
        expect_out(0, 1'b0, "R7 restart from zero");
        for (int i = 0; i < 25; i++) begin
            pa = ((i % 5) < 3);
            a_pe[2] = pa;
            expect_out(0, qa, "R5 R6 in2 divide");
            tick();
            if (pa && !pra) qa = ~qa;
            pra = pa;
        end

        // R9: chain two dividers
        wr_both(3'd5, 8'h00, 8'h00);
        a_pe = 3'b000;
        b_po = 3'b001;
        wr_b(3'd2, 8'h02);
        wr_b(3'd0, 8'h55);
        wr_b(3'd1, 8'hAA);
        wr_b(3'd3, 8'h01);
        wr_b(3'd4, 8'h1F);
        wr_both(3'd5, 8'h01, 8'h01);
        qa = 0; qb = 0; pra = 0; prb = 0;
        for (int i = 0; i < 40; i++) begin
            pa = (i % 2 == 0);
            a_pe[2] = pa;
            expect_out(0, qa, "R9 first stage");
            expect_out(1, qb, "R9 chained stage");
            tick();
            eb  = qa && !prb;
            prb = qa;
            if (eb) qb = ~qb;
            if (pa && !pra) qa = ~qa;
            pra = pa;
        end

        tick(); tick();
        done = 1;
        finish_run();
    end

endmodule